// File: doc/BRIEF.md
# Programmable Waveform Bus Master

This block masters an external parallel bus. It does not use fixed bus timing. It runs a short program of steps held in an internal step table, and software fills that table before a transfer. Each step is one of two kinds. A drive step places a 6-bit pattern on the control strobes for a programmed number of cycles. A wait step stalls until a chosen subset of six ready lines matches a required pattern. One pass through the program is a single waveform, and that waveform moves one data item or a burst of items between the internal side and an external device.

A run begins with a start pulse while the block is idle. The run always enters at step 0 and ends after the step flagged as final, or after the highest-numbered step. The block then returns a one-cycle completion pulse. Any step can be marked as a transfer step. A transfer step either drives the outbound data word onto the bus or samples the inbound bus at its last cycle. A 6-bit address output can advance after each transfer. A run-time select chooses an 8-bit or 16-bit data lane. A programmable limit bounds each wait step. When a wait step reaches that limit, the run is abandoned and an error indication is raised.

Top module: `wfm_bus_master`

## Requirements
- R1: While reset is asserted and after it is released, `ctl_o`, `adr_o`, `bus_oe`, `busy`, `done`, `rd_valid` and `timeout_err` are all zero.
- R2: A start pulse while idle makes `busy` high on the next cycle, with step 0 executing. A start pulse while `busy` is high has no effect on the run.
- R3: A drive step shows its control value on `ctl_o` for exactly hold+1 cycles. During wait steps and while idle, `ctl_o` keeps the value that was last driven.
- R4: A wait step finishes in the first cycle in which `(rdy_i & mask) == (match & mask)`. It then moves to the next step on the following cycle. A zero mask therefore passes in one cycle.
- R5: If `timeout_limit` is a nonzero value L and a wait step stays unmet for L cycles, the run ends. `timeout_err` is then set and `done` pulses. `timeout_err` stays set until the next start, which clears it. If the limit is zero, a wait step can stall for any length of time.
- R6: `done` is high for exactly one cycle. That cycle is the one after the last cycle of a step with the final flag set, or after the last cycle of step NUM_STEPS-1.
- R7: `adr_o` loads `addr_start` at start. When `auto_inc` is high, `adr_o` increases by one (modulo 64) after each transfer step. At all other times it is unchanged.
- R8: `bus_oe` is high exactly during the cycles of a transfer step whose direction bit is 1. While `bus_oe` is high, `bus_dout` equals `wr_data`. When `wide` is 0, the upper byte of `bus_dout` is forced to zero.
- R9: A transfer step whose direction bit is 0 samples `bus_din` in its last cycle. On the next cycle `rd_valid` pulses high and `rd_data` holds the sampled word. When `wide` is 0, the upper byte of the sampled word is zero.
- R10: When `tbl_we` is high, the clock edge stores `tbl_wdata` into step `tbl_addr`, and a later write to the same step replaces it. The step word layout is:
  - bit 0: opcode (0 = drive, 1 = wait)
  - [6:1]: control value
  - [12:7]: ready mask
  - [18:13]: ready match
  - [19]: transfer
  - [20]: direction (1 = out)
  - [21]: final
  - [29:22]: hold count

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Step table write enable |
| tbl_addr | input | $clog2(NUM_STEPS) | Step index to write |
| tbl_wdata | input | 30 | Step word to write |
| start | input | 1 | Begin a waveform at step 0 |
| timeout_limit | input | TO_W | Wait-step cycle limit, 0 = unlimited |
| addr_start | input | 6 | Address loaded at start |
| auto_inc | input | 1 | Advance address after transfer steps |
| wide | input | 1 | 1 = 16-bit lane, 0 = 8-bit lane |
| wr_data | input | DATA_W | Outbound data word |
| rdy_i | input | 6 | Ready inputs from the device |
| bus_din | input | DATA_W | Inbound data bus |
| ctl_o | output | 6 | Control strobes |
| adr_o | output | 6 | Address outputs |
| bus_dout | output | DATA_W | Outbound data bus |
| bus_oe | output | 1 | Data bus output enable |
| rd_data | output | DATA_W | Last sampled inbound word |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| busy | output | 1 | A waveform is executing |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Last run ended on a wait timeout |

## Verification
The bench builds the block with an eight-step table, a 16-bit data lane and an 8-bit timeout width. With the 16-bit lane, the `wide` select can be exercised in both positions on the same instance, so masking of the upper byte on both send and receive is observable. With eight steps, a program without a final flag can run to the implicit end of the table. A small timeout limit makes abort runs short. The limit can also be set to zero to show an unbounded stall that is released only by the ready lines.

// File: rtl/wfm_pkg.sv
package wfm_pkg;

    localparam int SIG_W  = 6;
    localparam int HOLD_W = 8;

    typedef enum logic {
        OP_DRIVE = 1'b0,
        OP_WAIT  = 1'b1
    } op_e;

    // Step word, LSB first: op, ctl, mask, match, xfer, dir, last, hold
    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic              last;
        logic              dir;
        logic              xfer;
        logic [SIG_W-1:0]  match;
        logic [SIG_W-1:0]  mask;
        logic [SIG_W-1:0]  ctl;
        op_e               op;
    } step_t;

    localparam int STEP_W = $bits(step_t);

endpackage

// File: rtl/wfm_step_table.sv
module wfm_step_table
    import wfm_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  step_t         wdata,
    input  logic [AW-1:0] raddr,
    output step_t         rdata
);

    step_t view [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        step_t ent_d;
        step_t ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && (waddr == AW'(g))) begin
                ent_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign view[g] = ent_q;
    end

    assign rdata = view[raddr];

endmodule

// File: rtl/wfm_ready_cmp.sv
module wfm_ready_cmp #(
    parameter int W = 6
) (
    input  logic [W-1:0] rdy,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] match,
    output logic         hit
);

    logic [W-1:0] miss;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign miss[g] = mask[g] & (rdy[g] ^ match[g]);
    end

    assign hit = ~|miss;

endmodule

// File: rtl/wfm_sequencer.sv
module wfm_sequencer
    import wfm_pkg::*;
#(
    parameter  int NUM_STEPS = 8,
    parameter  int TO_W      = 16,
    localparam int PC_W      = $clog2(NUM_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SIG_W-1:0]  addr_start,
    input  logic              auto_inc,
    input  logic [TO_W-1:0]   to_limit,
    input  op_e               op,
    input  logic [SIG_W-1:0]  ctl,
    input  logic [HOLD_W-1:0] hold,
    input  logic              last,
    input  logic              xfer,
    input  logic              rdy_hit,
    output logic [PC_W-1:0]   pc,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [SIG_W-1:0]  ctl_o,
    output logic [SIG_W-1:0]  adr_o,
    output logic              advance
);

    localparam int            CNT_W   = (TO_W > HOLD_W) ? TO_W : HOLD_W;
    localparam logic [PC_W-1:0] LAST_PC = PC_W'(NUM_STEPS - 1);

    typedef enum logic { ST_IDLE = 1'b0, ST_EXEC = 1'b1 } st_e;

    typedef struct packed {
        st_e              st;
        logic [PC_W-1:0]  pc;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             err;
        logic [SIG_W-1:0] ctl;
        logic [SIG_W-1:0] adr;
    } seq_t;

    seq_t q, n;

    logic [TO_W-1:0] lim_m1;
    logic            to_on;
    logic            step_end;
    logic            abort;

    assign lim_m1 = to_limit - TO_W'(1);
    assign to_on  = (to_limit != '0);

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        ctl_o    = q.ctl;
        advance  = 1'b0;
        step_end = 1'b0;
        abort    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.st  = ST_EXEC;
                    n.pc  = '0;
                    n.cnt = '0;
                    n.err = 1'b0;
                    n.adr = addr_start;
                end
            end
            ST_EXEC: begin
                if (op == OP_DRIVE) begin
                    ctl_o    = ctl;
                    n.ctl    = ctl;
                    step_end = (q.cnt == CNT_W'(hold));
                end else begin
                    step_end = rdy_hit;
                    abort    = !rdy_hit && to_on && (q.cnt == CNT_W'(lim_m1));
                end
                if (step_end) begin
                    advance = 1'b1;
                    n.cnt   = '0;
                    if (xfer && auto_inc) begin
                        n.adr = q.adr + SIG_W'(1);
                    end
                    if (last || (q.pc == LAST_PC)) begin
                        n.st   = ST_IDLE;
                        n.done = 1'b1;
                    end else begin
                        n.pc = q.pc + PC_W'(1);
                    end
                end else if (abort) begin
                    n.st   = ST_IDLE;
                    n.err  = 1'b1;
                    n.done = 1'b1;
                    n.cnt  = '0;
                end else begin
                    n.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign pc    = q.pc;
    assign busy  = (q.st == ST_EXEC);
    assign done  = q.done;
    assign err   = q.err;
    assign adr_o = q.adr;

    assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && pc == '0));

    assert_ctl_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op == OP_WAIT) |-> $stable(ctl_o));

    assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op == OP_WAIT && !rdy_hit) |=> $stable(pc));

    assert_err_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_adr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(busy && advance && xfer) && !(!busy && start)) |=> $stable(adr_o));

endmodule

// File: rtl/wfm_data_path.sv
module wfm_data_path #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              busy,
    input  logic              advance,
    input  logic              xfer,
    input  logic              dir,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t q, n;
    logic [DATA_W-1:0] lane_mask;

    always_comb begin
        lane_mask = '1;
        if (!wide) begin
            lane_mask = DATA_W'(8'hFF);
        end
        n       = q;
        n.valid = 1'b0;
        if (busy && advance && xfer && !dir) begin
            n.data  = bus_din & lane_mask;
            n.valid = 1'b1;
        end
        bus_oe   = busy && xfer && dir;
        bus_dout = bus_oe ? (wr_data & lane_mask) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign rd_data  = q.data;
    assign rd_valid = q.valid;

    assert_rdv_after_exec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(busy));

endmodule

// File: rtl/wfm_bus_master.sv
module wfm_bus_master
    import wfm_pkg::*;
#(
    parameter  int NUM_STEPS = 8,
    parameter  int DATA_W    = 16,
    parameter  int TO_W      = 16,
    localparam int PC_W      = $clog2(NUM_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [PC_W-1:0]   tbl_addr,
    input  logic [STEP_W-1:0] tbl_wdata,
    input  logic              start,
    input  logic [TO_W-1:0]   timeout_limit,
    input  logic [SIG_W-1:0]  addr_start,
    input  logic              auto_inc,
    input  logic              wide,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SIG_W-1:0]  rdy_i,
    input  logic [DATA_W-1:0] bus_din,
    output logic [SIG_W-1:0]  ctl_o,
    output logic [SIG_W-1:0]  adr_o,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              timeout_err
);

    step_t           cur;
    logic [PC_W-1:0] pc;
    logic            rdy_hit;
    logic            advance;

    wfm_step_table #(.DEPTH(NUM_STEPS)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .raddr (pc),
        .rdata (cur)
    );

    wfm_ready_cmp #(.W(SIG_W)) u_cmp (
        .rdy   (rdy_i),
        .mask  (cur.mask),
        .match (cur.match),
        .hit   (rdy_hit)
    );

    wfm_sequencer #(.NUM_STEPS(NUM_STEPS), .TO_W(TO_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .addr_start (addr_start),
        .auto_inc   (auto_inc),
        .to_limit   (timeout_limit),
        .op         (cur.op),
        .ctl        (cur.ctl),
        .hold       (cur.hold),
        .last       (cur.last),
        .xfer       (cur.xfer),
        .rdy_hit    (rdy_hit),
        .pc         (pc),
        .busy       (busy),
        .done       (done),
        .err        (timeout_err),
        .ctl_o      (ctl_o),
        .adr_o      (adr_o),
        .advance    (advance)
    );

    wfm_data_path #(.DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (wide),
        .busy     (busy),
        .advance  (advance),
        .xfer     (cur.xfer),
        .dir      (cur.dir),
        .wr_data  (wr_data),
        .bus_din  (bus_din),
        .bus_oe   (bus_oe),
        .bus_dout (bus_dout),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: tb/wfm_bus_master_test.sv
`timescale 1ns/1ps
module wfm_bus_master_test;

    localparam logic OPD = 1'b0;
    localparam logic OPW = 1'b1;

    // vectors: mask, match, rdy, pass flag
    localparam logic [23:0] VEC [6] = '{
        {6'h00, 6'h3F, 6'h00, 6'h01},
        {6'h3F, 6'h15, 6'h15, 6'h01},
        {6'h3F, 6'h15, 6'h14, 6'h00},
        {6'h0F, 6'h05, 6'h35, 6'h01},
        {6'h20, 6'h20, 6'h1F, 6'h00},
        {6'h21, 6'h01, 6'h01, 6'h01}
    };

    logic        clk;
    logic        rst_n;
    logic        tbl_we;
    logic [2:0]  tbl_addr;
    logic [29:0] tbl_wdata;
    logic        start;
    logic [7:0]  timeout_limit;
    logic [5:0]  addr_start;
    logic        auto_inc;
    logic        wide;
    logic [15:0] wr_data;
    logic [5:0]  rdy_i;
    logic [15:0] bus_din;
    logic [5:0]  ctl_o;
    logic [5:0]  adr_o;
    logic [15:0] bus_dout;
    logic        bus_oe;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        busy;
    logic        done;
    logic        timeout_err;

    int nchk = 0;
    int nfail = 0;

    wfm_bus_master #(.NUM_STEPS(8), .DATA_W(16), .TO_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .start(start), .timeout_limit(timeout_limit),
        .addr_start(addr_start), .auto_inc(auto_inc), .wide(wide),
        .wr_data(wr_data), .rdy_i(rdy_i), .bus_din(bus_din), .ctl_o(ctl_o),
        .adr_o(adr_o), .bus_dout(bus_dout), .bus_oe(bus_oe), .rd_data(rd_data),
        .rd_valid(rd_valid), .busy(busy), .done(done), .timeout_err(timeout_err)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [29:0] mk(input logic op, input logic [5:0] c,
        input logic [5:0] msk, input logic [5:0] mt, input logic x,
        input logic d, input logic l, input logic [7:0] h);
        return {h, l, d, x, mt, msk, c, op};
    endfunction

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [29:0] w);
        tbl_addr  = a;
        tbl_wdata = w;
        tbl_we    = 1'b1;
        tick;
        tbl_we    = 1'b0;
    endtask

    task automatic go;
        start = 1'b1;
        tick;
        start = 1'b0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_run;
    end

    initial begin
        int n;
        rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0; start = 1'b0;
        timeout_limit = 8'd4; addr_start = '0; auto_inc = 1'b0; wide = 1'b1;
        wr_data = '0; rdy_i = '0; bus_din = '0;
        repeat (3) tick;
        // R1 reset state
        chk("R1 ctl_o", 32'(ctl_o), 32'h0);
        chk("R1 adr_o", 32'(adr_o), 32'h0);
        chk("R1 flags", 32'({bus_oe, busy, done, rd_valid, timeout_err}), 32'h0);
        rst_n = 1'b1;
        tick;
        chk("R1 after release", 32'({busy, done, timeout_err, bus_oe}), 32'h0);

        // R4 / R5 vector walk: wait step then a final drive step, limit 4
        for (int v = 0; v < 6; v++) begin
            logic [5:0] vm;
            logic [5:0] vt;
            logic [5:0] vr;
            logic       ok;
            vm = VEC[v][23:18];
            vt = VEC[v][17:12];
            vr = VEC[v][11:6];
            ok = VEC[v][0];
            wr(3'd0, mk(OPW, 6'h00, vm, vt, 1'b0, 1'b0, 1'b0, 8'd0));
            wr(3'd1, mk(OPD, 6'h2A, 6'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'd0));
            rdy_i = vr;
            go;
            n = 0;
            while (!done && n < 12) begin
                tick;
                n++;
            end
            chk(ok ? "R4 match done cycle" : "R5 timeout done cycle", 32'(n), ok ? 32'd2 : 32'd4);
            chk("R5 timeout_err", 32'(timeout_err), ok ? 32'd0 : 32'd1);
            tick;
        end
        rdy_i = '0;

        // R3 drive hold timing and hold at idle
        wr(3'd0, mk(OPD, 6'h11, 6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 8'd2));
        wr(3'd1, mk(OPD, 6'h22, 6'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'd0));
        go;
        for (int i = 0; i < 5; i++) begin
            chk("R3 ctl_o per cycle", 32'(ctl_o), (i < 3) ? 32'h11 : 32'h22);
            if (i == 4) chk("R6 done after final step", 32'({done, busy}), 32'h2);
            tick;
        end
        chk("R3 ctl_o held at idle", 32'(ctl_o), 32'h22);
        chk("R6 done one cycle", 32'(done), 32'h0);

        // R2 start during a run is ignored
        wr(3'd0, mk(OPD, 6'h01, 6'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'd5));
        go;
        chk("R2 busy after start", 32'(busy), 32'h1);
        tick;
        start = 1'b1;
        tick;
        start = 1'b0;
        n = 2;
        while (!done && n < 20) begin
            tick;
            n++;
        end
        chk("R2 restart ignored", 32'(n), 32'd6);
        tick;

        // R7 R8 R9 transfers, 8-bit lane with auto increment
        addr_start = 6'h3E; auto_inc = 1'b1; wide = 1'b0;
        wr_data = 16'hABCD; bus_din = 16'h1234;
        wr(3'd0, mk(OPD, 6'h01, 6'h00, 6'h00, 1'b1, 1'b1, 1'b0, 8'd1));
        wr(3'd1, mk(OPD, 6'h02, 6'h00, 6'h00, 1'b1, 1'b1, 1'b0, 8'd0));
        wr(3'd2, mk(OPW, 6'h00, 6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 8'd0));
        wr(3'd3, mk(OPD, 6'h04, 6'h00, 6'h00, 1'b1, 1'b0, 1'b1, 8'd0));
        go;
        chk("R8 narrow out", 32'({bus_oe, bus_dout}), 32'h100CD);
        chk("R7 start addr", 32'(adr_o), 32'h3E);
        tick;
        chk("R7 addr within step", 32'(adr_o), 32'h3E);
        tick;
        chk("R7 addr inc", 32'(adr_o), 32'h3F);
        chk("R8 oe second out step", 32'(bus_oe), 32'h1);
        tick;
        chk("R7 addr wraps", 32'(adr_o), 32'h00);
        chk("R8 oe off on wait", 32'(bus_oe), 32'h0);
        chk("R3 ctl kept during wait", 32'(ctl_o), 32'h02);
        tick;
        chk("R8 oe off on read", 32'(bus_oe), 32'h0);
        chk("R9 no early strobe", 32'(rd_valid), 32'h0);
        tick;
        chk("R9 narrow capture", 32'({rd_valid, rd_data}), 32'h10034);
        chk("R7 addr after read", 32'(adr_o), 32'h01);
        tick;
        chk("R9 strobe one cycle", 32'(rd_valid), 32'h0);

        // R7 R8 R9 wide lane, no increment
        auto_inc = 1'b0; wide = 1'b1;
        go;
        chk("R8 wide out", 32'(bus_dout), 32'hABCD);
        repeat (5) tick;
        chk("R9 wide capture", 32'({rd_valid, rd_data}), 32'h11234);
        chk("R7 addr fixed", 32'(adr_o), 32'h3E);
        tick;

        // R5 sticky error, cleared by start, unlimited wait
        timeout_limit = 8'd2;
        wr(3'd0, mk(OPW, 6'h00, 6'h01, 6'h01, 1'b0, 1'b0, 1'b0, 8'd0));
        wr(3'd1, mk(OPD, 6'h05, 6'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'd0));
        rdy_i = 6'h00;
        go;
        n = 0;
        while (!done && n < 12) begin
            tick;
            n++;
        end
        chk("R5 limit 2 abort cycle", 32'(n), 32'd2);
        repeat (3) tick;
        chk("R5 error sticky idle", 32'({timeout_err, busy}), 32'h2);
        timeout_limit = 8'd0;
        go;
        chk("R5 error cleared on start", 32'(timeout_err), 32'h0);
        repeat (30) tick;
        chk("R5 unlimited wait", 32'({busy, timeout_err}), 32'h2);
        rdy_i = 6'h01;
        tick;
        chk("R4 release then drive", 32'(ctl_o), 32'h05);
        tick;
        chk("R6 done after release", 32'(done), 32'h1);
        rdy_i = 6'h00;
        tick;

        // R6 implicit end at the last table step
        for (int i = 0; i < 8; i++) begin
            wr(3'(i), mk(OPD, 6'(i + 8), 6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 8'd0));
        end
        go;
        for (int i = 0; i < 8; i++) begin
            chk("R6 sequential steps", 32'(ctl_o), 32'(i + 8));
            tick;
        end
        chk("R6 implicit end", 32'({done, busy}), 32'h2);
        tick;
        chk("R6 done cleared", 32'(done), 32'h0);

        // R10 overwrite of a step
        wr(3'd0, mk(OPD, 6'h3F, 6'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'd0));
        wr(3'd0, mk(OPD, 6'h15, 6'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'd0));
        go;
        chk("R10 rewritten step", 32'(ctl_o), 32'h15);
        tick;
        chk("R10 final flag honoured", 32'(done), 32'h1);

        finish_run;
    end

endmodule